// File: doc/BRIEF.md
# Double-Buffered Asynchronous Frame Transmitter

This block turns a parallel data word into one asynchronous serial frame on a single transmit line. A host writes a word through a simple write strobe. The word waits in a holding register that is separate from the shift register, so the next word can be queued while the current frame is still going out. Two flags tell the host when the holding register is free again and when the line has gone fully quiet.

The bit rate comes from outside as a single-cycle tick enable. Each bit lasts a fixed number of ticks, and a double-speed input halves that number. The data length, the parity and the stop-bit count are runtime inputs. They are captured together with the word at the moment the word moves into the shift register, so changing them during a frame has no effect on that frame.

Top module: `uframe_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1. Reset also leaves `buf_empty` = 1 and `tx_done` = 0.
- R2: A frame is placed on `txd` in this order: one start bit of value 0, then the data bits with the least significant bit first, then the parity bit if it is enabled, then the stop bits of value 1. The start bit appears on `txd` two cycles after the clock edge that accepts a word into an empty, idle block.
- R3: `cfg_len` selects the data length: 0, 1, 2, 3 and 4 select 5, 6, 7, 8 and 9 bits, and 5 to 7 also select 9. Bits of `wr_data` above the selected length are not sent.
- R4: Each bit stays on `txd` for exactly 16 rising edges with `tick_en` high, or for 8 when `dbl_speed` is 1. The first counted tick is the first one after the edge that loads the frame.
- R5: `cfg_parity` 2'b00 and 2'b01 send no parity bit. 2'b10 sends even parity, which is the XOR of the sent data bits. 2'b11 sends odd parity, which is the inverse of that XOR.
- R6: `cfg_two_stop` = 0 sends one stop bit and 1 sends two.
- R7: A write is accepted only while `buf_empty` is 1. `buf_empty` drops the cycle after an accepted write. It rises again the cycle after the word moves into an idle shift register. A word can therefore be written while the previous frame is still shifting, and it is sent after that frame.
- R8: A write while `buf_empty` is 0 is ignored. The waiting word is neither overwritten nor duplicated, and `buf_empty` stays 0.
- R9: `tx_done` rises in the cycle after the last stop bit ends, provided no word is waiting. If a word is waiting, `tx_done` stays 0 and the next frame starts.
- R10: `tx_done` is cleared by an accepted write or by `done_clr`. Either of these wins over a set in the same cycle.
- R11: The length, parity, stop-bit and double-speed settings are captured when a word moves into the shift register. Changes made after that point do not affect the frame being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Baud tick enable, one cycle per tick |
| dbl_speed | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| cfg_len | input | 3 | Data length select (0..4 gives 5..9 bits) |
| cfg_parity | input | 2 | Parity mode (0x none, 10 even, 11 odd) |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one stop bit |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 9 | Data word to send |
| done_clr | input | 1 | Clears `tx_done` |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding register can accept a word |
| tx_done | output | 1 | Last frame has fully left and nothing is waiting |

## Verification
The bench builds the block with the default of 16 ticks per bit. The double-speed input therefore gives both the 16-tick and the 8-tick bit period. With a 9-bit word port, every length from 5 to 9 is reachable, and so is the longest 13-bit frame with parity and two stop bits. The tick enable is irregular and random, so bit boundaries fall at uneven cycle spacing. Random back-to-back writes land at every point of a frame, including the edge where a frame ends, and this exercises the clear-over-set rule of `tx_done`.

// File: rtl/uframe_pkg.sv
package uframe_pkg;

    // Widest word and longest frame: start + 9 data + parity + 2 stop
    localparam int DMAX = 9;
    localparam int FMAX = 1 + DMAX + 1 + 2;
    localparam int LENW = $clog2(FMAX + 1);

    typedef enum logic [1:0] {
        PAR_OFF   = 2'b00,
        PAR_OFF_B = 2'b01,
        PAR_EVEN  = 2'b10,
        PAR_ODD   = 2'b11
    } par_e;

    // A fully assembled frame, bit 0 goes out first
    typedef struct packed {
        logic [FMAX-1:0] bits;
        logic [LENW-1:0] len;
        logic            fast;
    } frame_t;

    function automatic int data_len(input logic [2:0] sel);
        return (sel > 3'd4) ? DMAX : int'(sel) + 5;
    endfunction

    function automatic frame_t build_frame(input logic [DMAX-1:0] d,
                                           input logic [2:0]      sel,
                                           input par_e            par,
                                           input logic            two_stop,
                                           input logic            fast);
        frame_t f;
        int     n;
        int     pos;
        logic   x;
        n      = data_len(sel);
        f.bits = '1;
        f.bits[0] = 1'b0;
        x      = 1'b0;
        for (int i = 0; i < DMAX; i++) begin
            if (i < n) begin
                f.bits[1 + i] = d[i];
                x = x ^ d[i];
            end
        end
        pos = n + 1;
        if (par[1]) begin
            f.bits[pos] = par[0] ? ~x : x;
            pos++;
        end
        pos = pos + (two_stop ? 2 : 1);
        f.len  = LENW'(pos);
        f.fast = fast;
        return f;
    endfunction

endpackage

// File: rtl/uframe_hold.sv
module uframe_hold
    import uframe_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [DMAX-1:0] wr_data,
    input  logic            take,
    output logic            full,
    output logic [DMAX-1:0] data_q,
    output logic            accepted
);

    assign accepted = wr_en && !full;

    always_ff @(posedge clk) begin
        if (rst) begin
            full   <= 1'b0;
            data_q <= '0;
        end else if (accepted) begin
            full   <= 1'b1;
            data_q <= wr_data;
        end else if (take) begin
            full   <= 1'b0;
        end
    end

    // R8: a write that meets a full register leaves the waiting word alone
    a_r8_keep_word: assert property (@(posedge clk) disable iff (rst)
        full && wr_en |=> $stable(data_q));

    // R7: the shifter only takes a word that is really there
    a_r7_take_full: assert property (@(posedge clk) disable iff (rst)
        take |-> full);

endmodule

// File: rtl/uframe_baud.sv
module uframe_baud #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic restart,
    input  logic fast,
    output logic bit_end
);

    localparam int CW = $clog2(OSR);

    logic [CW-1:0] cnt;
    logic          fast_q;
    logic [CW-1:0] last;

    assign last    = fast_q ? CW'(OSR / 2 - 1) : CW'(OSR - 1);
    assign bit_end = tick_en && !restart && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            fast_q <= 1'b0;
        end else if (restart) begin
            cnt    <= '0;
            fast_q <= fast;
        end else if (tick_en) begin
            cnt    <= (cnt == last) ? '0 : cnt + 1'b1;
        end
    end

    // R4: the tick counter never passes the bit length in use
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= last);

    // R4: a new frame always starts counting from zero
    a_r4_restart_zero: assert property (@(posedge clk) disable iff (rst)
        restart |=> cnt == '0);

endmodule

// File: rtl/uframe_shift.sv
module uframe_shift
    import uframe_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t frame_in,
    input  logic   bit_end,
    output logic   txd,
    output logic   busy,
    output logic   frame_end
);

    logic [FMAX-1:0] sh;
    logic [LENW-1:0] left;

    assign frame_end = busy && bit_end && (left == LENW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '1;
            left <= '0;
            txd  <= 1'b1;
            busy <= 1'b0;
        end else if (load) begin
            sh   <= frame_in.bits;
            left <= frame_in.len;
            txd  <= frame_in.bits[0];
            busy <= 1'b1;
        end else if (busy && bit_end) begin
            if (left == LENW'(1)) begin
                busy <= 1'b0;
                txd  <= 1'b1;
            end else begin
                sh   <= {1'b1, sh[FMAX-1:1]};
                txd  <= sh[1];
                left <= left - 1'b1;
            end
        end
    end

    // R1: the line rests high between frames
    a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    // R2: every frame opens with a low start bit
    a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
        load |=> !txd);

    // R6: the bit that closes a frame is a high stop bit
    a_r6_stop_high: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> txd);

    // R7: a frame is never loaded over one in flight
    a_r7_load_idle: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy);

endmodule

// File: rtl/uframe_tx.sv
module uframe_tx
    import uframe_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_en,
    input  logic            dbl_speed,
    input  logic [2:0]      cfg_len,
    input  logic [1:0]      cfg_parity,
    input  logic            cfg_two_stop,
    input  logic            wr_en,
    input  logic [DMAX-1:0] wr_data,
    input  logic            done_clr,
    output logic            txd,
    output logic            buf_empty,
    output logic            tx_done
);

    logic            full;
    logic [DMAX-1:0] held;
    logic            accepted;
    logic            busy;
    logic            load;
    logic            bit_end;
    logic            frame_end;
    frame_t          next_frame;

    assign load       = full && !busy;
    assign buf_empty  = !full;
    assign next_frame = build_frame(held, cfg_len, par_e'(cfg_parity),
                                    cfg_two_stop, dbl_speed);

    uframe_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .take     (load),
        .full     (full),
        .data_q   (held),
        .accepted (accepted)
    );

    uframe_baud #(.OSR(OSR)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .restart (load),
        .fast    (dbl_speed),
        .bit_end (bit_end)
    );

    uframe_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .frame_in  (next_frame),
        .bit_end   (bit_end),
        .txd       (txd),
        .busy      (busy),
        .frame_end (frame_end)
    );

    // Clear wins over set
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_done <= 1'b0;
        end else if (accepted || done_clr) begin
            tx_done <= 1'b0;
        end else if (frame_end && !full) begin
            tx_done <= 1'b1;
        end
    end

    // R9: completion is never shown while a frame is on the line
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> !busy);

    // R9: the last stop bit ending with nothing queued raises completion
    a_r9_done_set: assert property (@(posedge clk) disable iff (rst)
        frame_end && !full && !accepted && !done_clr |=> tx_done);

    // R10: an explicit clear always drops the flag
    a_r10_clr: assert property (@(posedge clk) disable iff (rst)
        done_clr |=> !tx_done);

    // R10: an accepted write always drops the flag
    a_r10_write_clr: assert property (@(posedge clk) disable iff (rst)
        accepted |=> !tx_done);

    // R7: moving a word into the shifter frees the holding register
    a_r7_free_after_load: assert property (@(posedge clk) disable iff (rst)
        load |=> buf_empty);

endmodule

// File: tb/uframe_tx_test.sv
module uframe_tx_test;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       dbl = 1'b0;
    logic [2:0] nsel = 3'd3;
    logic [1:0] par = 2'b00;
    logic       stop2 = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wdata = '0;
    logic       done_clr = 1'b0;
    logic       txd;
    logic       buf_empty;
    logic       tx_done;

    always #2.5 clk = ~clk;

    uframe_tx uut (
        .clk          (clk),
        .rst          (rst),
        .tick_en      (tick_en),
        .dbl_speed    (dbl),
        .cfg_len      (nsel),
        .cfg_parity   (par),
        .cfg_two_stop (stop2),
        .wr_en        (wr_en),
        .wr_data      (wdata),
        .done_clr     (done_clr),
        .txd          (txd),
        .buf_empty    (buf_empty),
        .tx_done      (tx_done)
    );

    typedef struct {
        logic [8:0] d;
        int         nb;
        logic [1:0] pm;
        logic       s2;
        logic       fast;
    } ent_t;

    ent_t q[$];
    int   errors = 0;
    int   checks = 0;
    int   frames = 0;
    int   cyc = 0;
    bit   reported = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic int nb_of(input logic [2:0] s);
        return (s >= 3'd5) ? 9 : int'(s) + 5;
    endfunction

    // Expected line pattern, index 0 is sent first
    function automatic int exp_frame(input ent_t e, output logic [15:0] b);
        int         k;
        logic [8:0] m;
        b = '1;
        k = 0;
        b[k] = 1'b0; k++;
        for (int i = 0; i < e.nb; i++) begin
            b[k] = e.d[i]; k++;
        end
        m = 9'h1ff >> (9 - e.nb);
        if (e.pm == 2'b10) begin b[k] = ^(e.d & m);  k++; end
        if (e.pm == 2'b11) begin b[k] = ~^(e.d & m); k++; end
        k = k + (e.s2 ? 2 : 1);
        return k;
    endfunction

    function automatic string tag_of(input ent_t e, input int idx);
        if (idx == 0) return "R2";
        if (idx <= e.nb) return "R3";
        if (e.pm[1] && idx == e.nb + 1) return "R5";
        return "R6";
    endfunction

    // Line decoder: counts ticks after the start bit appears and
    // samples each bit halfway through its tick span
    bit          dbusy = 0;
    bit          prev_txd = 1;
    int          tcnt, sidx, flen, tpb;
    logic [15:0] fbits;
    ent_t        cur;

    always @(negedge clk) begin
        if (rst) begin
            dbusy    = 0;
            prev_txd = 1;
        end else begin
            if (dbusy) begin
                if (tick_en) begin
                    tcnt++;
                    if (sidx < flen && tcnt == sidx * tpb + tpb / 2) begin
                        chk(txd == fbits[sidx], tag_of(cur, sidx),
                            $sformatf("(R4 timing) frame %0d bit %0d", frames, sidx),
                            int'(txd), int'(fbits[sidx]));
                        sidx++;
                    end
                    if (tcnt == flen * tpb) begin
                        void'(q.pop_front());
                        frames++;
                        dbusy = 0;
                        chk(tx_done == (q.size() == 0), "R9",
                            "tx_done at frame end", int'(tx_done),
                            int'(q.size() == 0));
                    end
                end
            end else if (prev_txd && !txd) begin
                if (q.size() == 0) begin
                    chk(0, "R8", "start bit with no accepted word", 0, 1);
                end else begin
                    cur   = q[0];
                    flen  = exp_frame(cur, fbits);
                    tpb   = cur.fast ? 8 : 16;
                    tcnt  = 0;
                    sidx  = 0;
                    dbusy = 1;
                    chk(tx_done == 0, "R10", "tx_done cleared by write",
                        int'(tx_done), 0);
                end
            end
            prev_txd = txd;
        end
        tick_en = ($urandom_range(0, 3) != 0);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            chk(0, "watchdog", "run did not finish", cyc, 0);
            report();
        end
    end

    task automatic put(input logic [8:0] d);
        @(negedge clk); #0.5;
        wr_en = 1'b1;
        wdata = d;
        if (buf_empty) q.push_back('{d, nb_of(nsel), par, stop2, dbl});
        @(negedge clk); #0.5;
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (!(!dbusy && q.size() == 0 && tx_done && buf_empty) && n < 40000) begin
            @(negedge clk); #0.5;
            n++;
        end
        chk(tx_done == 1, "R9", "tx_done high when line quiet", int'(tx_done), 1);
        chk(txd == 1, "R1", "txd high when idle", int'(txd), 1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #0.5;
        chk(txd == 1, "R1", "txd in reset", int'(txd), 1);
        chk(buf_empty == 1, "R1", "buf_empty in reset", int'(buf_empty), 1);
        chk(tx_done == 0, "R1", "tx_done in reset", int'(tx_done), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        #0.5;
        chk(txd == 1, "R1", "txd idle after reset", int'(txd), 1);

        // Directed: 8 data bits, no parity, one stop bit; queue and overfill
        nsel = 3'd3; par = 2'b00; stop2 = 1'b0; dbl = 1'b0;
        wr_en = 1'b1; wdata = 9'h0a5;
        q.push_back('{9'h0a5, 8, 2'b00, 1'b0, 1'b0});
        @(negedge clk); #0.5;
        wr_en = 1'b0;
        chk(buf_empty == 0, "R7", "buf_empty after write", int'(buf_empty), 0);
        @(negedge clk); #0.5;
        chk(buf_empty == 1, "R7", "buf_empty after load", int'(buf_empty), 1);
        chk(txd == 0, "R2", "start bit two cycles after write", int'(txd), 0);
        wr_en = 1'b1; wdata = 9'h05a;
        q.push_back('{9'h05a, 8, 2'b00, 1'b0, 1'b0});
        @(negedge clk); #0.5;
        chk(buf_empty == 0, "R7", "second word queued while shifting", int'(buf_empty), 0);
        wdata = 9'h13c;
        @(negedge clk); #0.5;
        wr_en = 1'b0;
        chk(buf_empty == 0, "R8", "buf_empty after write into full register", int'(buf_empty), 0);
        wait_idle();
        chk(frames == 2, "R8", "frames sent (ignored word not sent)", frames, 2);

        // Explicit clear
        done_clr = 1'b1;
        @(negedge clk); #0.5;
        done_clr = 1'b0;
        chk(tx_done == 0, "R10", "tx_done after done_clr", int'(tx_done), 0);
        @(negedge clk); #0.5;
        chk(tx_done == 0, "R10", "tx_done stays low", int'(tx_done), 0);

        // Directed: settings changed after the load must not matter
        nsel = 3'd0; par = 2'b10; stop2 = 1'b1; dbl = 1'b1;
        put(9'h0b5);
        begin
            int n = 0;
            while (!dbusy && n < 100) begin @(negedge clk); #0.5; n++; end
        end
        nsel = 3'd4; par = 2'b11; stop2 = 1'b0; dbl = 1'b0;
        wait_idle();
        chk(frames == 3, "R11", "frame decoded with captured settings", frames, 3);

        // Directed: longest frame, 9 bits, odd parity, two stop bits
        nsel = 3'd4; par = 2'b11; stop2 = 1'b1; dbl = 1'b0;
        put(9'h1ff);
        put(9'h100);
        wait_idle();

        // Random batches
        for (int b = 0; b < 10; b++) begin
            nsel  = 3'($urandom_range(0, 7));
            par   = 2'($urandom_range(0, 3));
            stop2 = 1'($urandom_range(0, 1));
            dbl   = 1'($urandom_range(0, 1));
            for (int w = 0; w < 6; w++) begin
                int n = 0;
                while (!buf_empty && n < 20000) begin @(negedge clk); #0.5; n++; end
                repeat ($urandom_range(0, 3)) @(negedge clk);
                put(9'($urandom_range(0, 511)));
            end
            wait_idle();
        end

        chk(q.size() == 0, "R7", "all accepted words sent", q.size(), 0);
        report();
    end

endmodule